// File: doc/BRIEF.md
# Digital Potentiometer Register Executor

This block carries out already-decoded commands against a bank of four potentiometer channels. Each channel holds one volatile wiper register that sets the tap position and four data registers that stand in for a non-volatile store. A command selects an opcode, a channel and a data register. It can read or write either register type or copy a value between them on one channel. It can also copy between the wiper registers and one data register slot on all channels at once, or return a status byte.

A store into a data register models a slow non-volatile write. A down-counter keeps a busy flag high for a fixed number of clock cycles, and no further data register store is accepted while the flag is high. An active-low write-protect input blocks every data register store, including stores that come from a copy. Reset models a power cycle. The data registers take their shipped contents, and in the first clock after reset each wiper register loads data register 0 of its own channel.

Top module: `potbank_exec`

## Requirements
- R1: Reset sets data register j of channel c to NV_BASE + 16·c + j, taken modulo 256 (default NV_BASE is 0x40). Each wiper register loads data register 0 of its own channel on the first clock edge after rst_n goes high, and a command presented on that edge is ignored.
- R2: Opcode 4'b1001 (wiper read) raises rd_valid one cycle after the accepted command, with rd_data equal to the wiper register of channel cmd_chan.
- R3: Opcode 4'b1010 (wiper write) loads cmd_data into the wiper register of cmd_chan, and the new value is on wiper_bus[8·c +: 8] one cycle later. A wiper register changes only in response to a command or to the recall after reset.
- R4: Opcode 4'b1011 returns data register cmd_sel of channel cmd_chan on rd_data. Opcode 4'b1100 stores cmd_data into that register.
- R5: Opcode 4'b1101 copies data register cmd_sel of channel cmd_chan into that channel's wiper register. Opcode 4'b1110 copies that wiper register into data register cmd_sel of the same channel.
- R6: Opcode 4'b0001 loads every channel's wiper register from its own data register cmd_sel. Opcode 4'b1000 stores every channel's wiper register into its own data register cmd_sel. Both ignore cmd_chan.
- R7: Opcode 4'b0101 with cmd_sel = 0 and cmd_chan = 1 returns a byte that is zero except for bit 0, which equals nv_busy at the cycle of the command. With any other cmd_sel/cmd_chan the opcode gives no response.
- R8: An accepted data register store (opcodes 1100, 1110 and 1000) holds nv_busy high for exactly NV_CYCLES cycles, starting in the cycle after the command. nv_busy rises only after such a command.
- R9: While nv_busy is high, data register stores are ignored and do not extend the busy time. Reads, status reads, wiper writes and copies into wiper registers are still served.
- R10: When wp_n is low in the cycle of the command, data register stores (opcodes 1100, 1110 and 1000) change nothing and do not raise nv_busy. Wiper writes are still served.
- R11: Opcodes 0000, 0010, 0011, 0100, 0110, 0111 and 1111 have no effect: no rd_valid, no register change, no busy.
- R12: rd_valid is high only in the cycle after an accepted read or status command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; models power-up |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command opcode |
| cmd_sel | input | 2 | Data register index within a channel |
| cmd_chan | input | 2 | Channel index |
| cmd_data | input | 8 | Write data for wiper or data register writes |
| wp_n | input | 1 | Active-low write protect for data register stores |
| rd_valid | output | 1 | Read response strobe, one cycle |
| rd_data | output | 8 | Read response byte |
| wiper_bus | output | 32 | All four wiper registers, channel c in bits 8·c+7 to 8·c |
| nv_busy | output | 1 | Non-volatile write cycle in progress |

## Verification
On every cycle the assertions check the following. The busy flag never stays high longer than the write time and rises only after a store that was allowed. Write protect keeps it low. A read strobe never appears without a read or status command, and the status byte has its upper bits clear. Wipers stay still without a command, and unknown opcodes give no response. Register contents are shown only by the bench's directed scenarios: reset recall values, the targets of single-channel and all-channel copies, and data registers left intact after stores that were dropped under busy or write protect.

// File: rtl/potbank_pkg.sv
// Shared opcode encoding and decoded-action type for the potentiometer
// register executor. Assumes 4-bit opcodes as listed in the brief.
package potbank_pkg;

    typedef enum logic [3:0] {
        OP_GLOB_D2W = 4'b0001,
        OP_STATUS   = 4'b0101,
        OP_GLOB_W2D = 4'b1000,
        OP_RD_WIP   = 4'b1001,
        OP_WR_WIP   = 4'b1010,
        OP_RD_DR    = 4'b1011,
        OP_WR_DR    = 4'b1100,
        OP_XFER_D2W = 4'b1101,
        OP_XFER_W2D = 4'b1110
    } op_e;

    typedef struct packed {
        logic rd_wip;
        logic rd_dr;
        logic rd_stat;
        logic wr_wip;
        logic wr_dr;
        logic xfer_d2w;
        logic xfer_w2d;
        logic glob_d2w;
        logic glob_w2d;
    } act_t;

    // True for opcodes that store into a data register.
    function automatic logic op_stores_nv(input logic [3:0] op);
        return (op == OP_WR_DR) || (op == OP_XFER_W2D) || (op == OP_GLOB_W2D);
    endfunction

    // True for opcodes that produce a read response.
    function automatic logic op_is_read(input logic [3:0] op);
        return (op == OP_RD_WIP) || (op == OP_RD_DR) || (op == OP_STATUS);
    endfunction

    // True for opcodes the executor recognises.
    function automatic logic op_known(input logic [3:0] op);
        return op_stores_nv(op) || op_is_read(op) || (op == OP_WR_WIP) ||
               (op == OP_XFER_D2W) || (op == OP_GLOB_D2W);
    endfunction

endpackage

// File: rtl/potbank_decode.sv
// Command decoder: turns one command into action enables.
// Drops all commands during the recall cycle, and drops data register
// stores while a write cycle runs or write protect is low.
// Assumes the status command needs register select 0 and channel 1.
module potbank_decode
    import potbank_pkg::*;
#(
    parameter int CW = 2,
    parameter int RW = 2
) (
    input  logic          cmd_valid,
    input  logic          recall,
    input  logic          nv_busy,
    input  logic          wp_n,
    input  logic [3:0]    cmd_op,
    input  logic [RW-1:0] cmd_sel,
    input  logic [CW-1:0] cmd_chan,
    output act_t          act,
    output logic          nv_start
);

    logic go;
    logic nv_ok;

    assign go    = cmd_valid && !recall;
    assign nv_ok = !nv_busy && wp_n;

    // Map opcode to a single action, gated by acceptance conditions.
    always_comb begin
        act = '0;
        case (op_e'(cmd_op))
            OP_RD_WIP:   act.rd_wip   = go;
            OP_RD_DR:    act.rd_dr    = go;
            OP_STATUS:   act.rd_stat  = go && (cmd_sel == '0) && (cmd_chan == CW'(1));
            OP_WR_WIP:   act.wr_wip   = go;
            OP_WR_DR:    act.wr_dr    = go && nv_ok;
            OP_XFER_D2W: act.xfer_d2w = go;
            OP_XFER_W2D: act.xfer_w2d = go && nv_ok;
            OP_GLOB_D2W: act.glob_d2w = go;
            OP_GLOB_W2D: act.glob_w2d = go && nv_ok;
            default:     act = '0;
        endcase
    end

    assign nv_start = act.wr_dr || act.xfer_w2d || act.glob_w2d;

endmodule

// File: rtl/potbank_nvtimer.sv
// Write-cycle timer: a down-counter loaded on each accepted store.
// busy is high for exactly NV_CYCLES cycles after the start cycle.
// Assumes NV_CYCLES >= 1 and that start never arrives while busy.
module potbank_nvtimer #(
    parameter int NV_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CNTW = $clog2(NV_CYCLES + 1);

    logic [CNTW-1:0] cnt_q;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CNTW'(NV_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/potbank_chan.sv
// One channel: a volatile wiper register and NREG data registers.
// Reset gives the data registers their shipped pattern
// NV_BASE + 16*CH_IDX + j, and clears the wiper, which the parent
// reloads in the recall cycle.
module potbank_chan #(
    parameter int W       = 8,
    parameter int NREG    = 4,
    parameter int RW      = 2,
    parameter int CH_IDX  = 0,
    parameter int NV_BASE = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wip_we,
    input  logic [W-1:0]             wip_d,
    input  logic                     dr_we,
    input  logic [RW-1:0]            dr_idx,
    input  logic [W-1:0]             dr_d,
    output logic [W-1:0]             wiper,
    output logic [NREG-1:0][W-1:0]   dr
);

    // Wiper register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wiper <= '0;
        else if (wip_we)
            wiper <= wip_d;
    end

    for (genvar j = 0; j < NREG; j++) begin : g_dr
        // Data register j: shipped value on reset, store when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dr[j] <= W'(NV_BASE + 16 * CH_IDX + j);
            else if (dr_we && (dr_idx == RW'(j)))
                dr[j] <= dr_d;
        end
    end

endmodule

// File: rtl/potbank_exec.sv
// Top of the potentiometer register executor. Runs decoded commands
// against NCH channels, times data register stores and serves reads
// one cycle after the command. Assumes the caller presents at most one
// command per cycle and holds wp_n stable around the command.
module potbank_exec
    import potbank_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int W         = 8,
    parameter int NREG      = 4,
    parameter int NV_CYCLES = 1000000,
    parameter int NV_BASE   = 64,
    localparam int CW       = $clog2(NCH),
    localparam int RW       = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [RW-1:0]     cmd_sel,
    input  logic [CW-1:0]     cmd_chan,
    input  logic [W-1:0]      cmd_data,
    input  logic              wp_n,
    output logic              rd_valid,
    output logic [W-1:0]      rd_data,
    output logic [NCH*W-1:0]  wiper_bus,
    output logic              nv_busy
);

    logic                               recall_q;
    act_t                               act;
    logic                               nv_start;
    logic [NCH-1:0][W-1:0]              wip_q;
    logic [NCH-1:0][NREG-1:0][W-1:0]    dr_q;

    // Flag the first cycle after reset as the recall cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            recall_q <= 1'b1;
        else
            recall_q <= 1'b0;
    end

    potbank_decode #(.CW(CW), .RW(RW)) u_decode (
        .cmd_valid (cmd_valid),
        .recall    (recall_q),
        .nv_busy   (nv_busy),
        .wp_n      (wp_n),
        .cmd_op    (cmd_op),
        .cmd_sel   (cmd_sel),
        .cmd_chan  (cmd_chan),
        .act       (act),
        .nv_start  (nv_start)
    );

    potbank_nvtimer #(.NV_CYCLES(NV_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nv_start),
        .busy  (nv_busy)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic          hit;
        logic          wip_we;
        logic [W-1:0]  wip_d;
        logic          dr_we;
        logic [W-1:0]  dr_d;

        assign hit    = (cmd_chan == CW'(c));
        assign wip_we = recall_q || ((act.wr_wip || act.xfer_d2w) && hit) || act.glob_d2w;
        assign wip_d  = recall_q   ? dr_q[c][0] :
                        act.wr_wip ? cmd_data   : dr_q[c][cmd_sel];
        assign dr_we  = ((act.wr_dr || act.xfer_w2d) && hit) || act.glob_w2d;
        assign dr_d   = act.wr_dr ? cmd_data : wip_q[c];

        potbank_chan #(
            .W       (W),
            .NREG    (NREG),
            .RW      (RW),
            .CH_IDX  (c),
            .NV_BASE (NV_BASE)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wip_we (wip_we),
            .wip_d  (wip_d),
            .dr_we  (dr_we),
            .dr_idx (cmd_sel),
            .dr_d   (dr_d),
            .wiper  (wip_q[c]),
            .dr     (dr_q[c])
        );

        assign wiper_bus[c*W +: W] = wip_q[c];
    end

    // Register the read response one cycle after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= act.rd_wip || act.rd_dr || act.rd_stat;
            if (act.rd_wip)
                rd_data <= wip_q[cmd_chan];
            else if (act.rd_dr)
                rd_data <= dr_q[cmd_chan][cmd_sel];
            else if (act.rd_stat)
                rd_data <= W'(nv_busy);
            else
                rd_data <= '0;
        end
    end

endmodule

// File: rtl/potbank_exec_chk.sv
// Assertion checker for potbank_exec, bound to every instance.
// Watches only ports; keeps its own reset-recall flag and busy run counter.
module potbank_exec_chk
    import potbank_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int W         = 8,
    parameter int NREG      = 4,
    parameter int NV_CYCLES = 1000000,
    localparam int CW       = $clog2(NCH),
    localparam int RW       = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [3:0]        cmd_op,
    input logic [RW-1:0]     cmd_sel,
    input logic [CW-1:0]     cmd_chan,
    input logic              wp_n,
    input logic              rd_valid,
    input logic [W-1:0]      rd_data,
    input logic [NCH*W-1:0]  wiper_bus,
    input logic              nv_busy
);

    logic        post_rst;
    logic [31:0] busy_run;

    // Mark the recall cycle that follows reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            post_rst <= 1'b1;
        else
            post_rst <= 1'b0;
    end

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_run <= '0;
        else
            busy_run <= nv_busy ? busy_run + 1 : '0;
    end

    assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nv_busy |-> (busy_run < 32'(NV_CYCLES)));

    assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_busy) |-> $past(cmd_valid && wp_n && op_stores_nv(cmd_op)));

    assert_wp_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !wp_n && !nv_busy && op_stores_nv(cmd_op)) |=> !nv_busy);

    assert_rd_only_after_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid && op_is_read(cmd_op)));

    assert_status_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(cmd_op == OP_STATUS)) |-> (rd_data[W-1:1] == '0));

    assert_status_nibble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_STATUS) && !((cmd_sel == '0) && (cmd_chan == CW'(1))))
        |=> !rd_valid);

    assert_wiper_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!post_rst && !cmd_valid) |=> $stable(wiper_bus));

    assert_unlisted_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!post_rst && cmd_valid && !op_known(cmd_op)) |=> (!rd_valid && $stable(wiper_bus)));

endmodule

bind potbank_exec potbank_exec_chk #(
    .NCH       (NCH),
    .W         (W),
    .NREG      (NREG),
    .NV_CYCLES (NV_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_sel   (cmd_sel),
    .cmd_chan  (cmd_chan),
    .wp_n      (wp_n),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .wiper_bus (wiper_bus),
    .nv_busy   (nv_busy)
);

// File: tb/potbank_exec_tb.sv
// Directed bench for potbank_exec: one task per scenario, reference
// values kept in a small model written from the requirements.
module potbank_exec_tb;
    import potbank_pkg::*;

    localparam int NV = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [1:0]  cmd_sel = '0;
    logic [1:0]  cmd_chan = '0;
    logic [7:0]  cmd_data = '0;
    logic        wp_n = 1'b1;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [31:0] wiper_bus;
    logic        nv_busy;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [7:0]  mw [4];
    logic [7:0]  md [4][4];
    logic        got_v;
    logic [7:0]  got_d;

    always #5 clk = ~clk;

    potbank_exec #(.NV_CYCLES(NV)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_sel   (cmd_sel),
        .cmd_chan  (cmd_chan),
        .cmd_data  (cmd_data),
        .wp_n      (wp_n),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .wiper_bus (wiper_bus),
        .nv_busy   (nv_busy)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one command for one clock, capture the response after it.
    task automatic issue(input logic [3:0] op, input logic [1:0] sel,
                         input logic [1:0] ch, input logic [7:0] d);
        @(negedge clk);
        cmd_op = op; cmd_sel = sel; cmd_chan = ch; cmd_data = d;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        got_v = rd_valid;
        got_d = rd_data;
    endtask

    task automatic wait_idle();
        while (nv_busy) @(negedge clk);
    endtask

    task automatic check_wipers(input string req);
        for (int c = 0; c < 4; c++)
            check_eq(req, 32'(wiper_bus[c*8 +: 8]), 32'(mw[c]));
    endtask

    task automatic read_dr(input string req, input logic [1:0] sel, input logic [1:0] ch);
        issue(OP_RD_DR, sel, ch, 8'h00);
        check_eq(req, 32'(got_v), 32'd1);
        check_eq(req, 32'(got_d), 32'(md[ch][sel]));
    endtask

    // R1: reset pattern and recall into wipers.
    task automatic t_reset_recall();
        for (int c = 0; c < 4; c++)
            for (int j = 0; j < 4; j++)
                md[c][j] = 8'(8'h40 + 16 * c + j);
        for (int c = 0; c < 4; c++) mw[c] = md[c][0];
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_wipers("R1 recall");
        check_eq("R1 busy after reset", 32'(nv_busy), 32'd0);
        check_eq("R1 rd_valid after reset", 32'(rd_valid), 32'd0);
        read_dr("R1 shipped pattern", 2'd3, 2'd2);
    endtask

    // R2, R3, R12: wiper write and read.
    task automatic t_wiper_rw();
        issue(OP_WR_WIP, 2'd0, 2'd2, 8'hA5);
        mw[2] = 8'hA5;
        check_eq("R12 no strobe on write", 32'(got_v), 32'd0);
        check_wipers("R3 wiper write");
        issue(OP_RD_WIP, 2'd0, 2'd2, 8'h00);
        check_eq("R2 strobe", 32'(got_v), 32'd1);
        check_eq("R2 data ch2", 32'(got_d), 32'hA5);
        issue(OP_RD_WIP, 2'd3, 2'd0, 8'h00);
        check_eq("R2 data ch0", 32'(got_d), 32'(mw[0]));
    endtask

    // R4, R8: data register store and busy length.
    task automatic t_dr_store();
        int n;
        read_dr("R4 read ch1 reg3", 2'd3, 2'd1);
        issue(OP_WR_DR, 2'd2, 2'd3, 8'h3C);
        md[3][2] = 8'h3C;
        n = 0;
        while (nv_busy && n < 10 * NV) begin
            n++;
            @(negedge clk);
        end
        check_eq("R8 busy length", 32'(n), 32'(NV));
        read_dr("R4 store readback", 2'd2, 2'd3);
    endtask

    // R9, R7: behaviour during a write cycle.
    task automatic t_busy_ignore();
        issue(OP_WR_DR, 2'd1, 2'd0, 8'h11);
        md[0][1] = 8'h11;
        check_eq("R8 busy starts", 32'(nv_busy), 32'd1);
        read_dr("R9 read during busy", 2'd2, 2'd3);
        issue(OP_STATUS, 2'd0, 2'd1, 8'h00);
        check_eq("R7 status strobe busy", 32'(got_v), 32'd1);
        check_eq("R7 status busy", 32'(got_d), 32'h01);
        issue(OP_WR_WIP, 2'd0, 2'd1, 8'h99);
        mw[1] = 8'h99;
        check_wipers("R9 wiper write during busy");
        issue(OP_WR_DR, 2'd2, 2'd0, 8'h22);
        wait_idle();
        read_dr("R9 dropped store", 2'd2, 2'd0);
        read_dr("R9 first store kept", 2'd1, 2'd0);
        issue(OP_STATUS, 2'd0, 2'd1, 8'h00);
        check_eq("R7 status idle", 32'(got_d), 32'h00);
    endtask

    // R5: single-channel copies.
    task automatic t_xfer();
        issue(OP_XFER_D2W, 2'd3, 2'd1, 8'h00);
        mw[1] = md[1][3];
        check_wipers("R5 data to wiper");
        issue(OP_XFER_W2D, 2'd1, 2'd2, 8'h00);
        md[2][1] = mw[2];
        check_eq("R5 copy starts busy", 32'(nv_busy), 32'd1);
        wait_idle();
        read_dr("R5 wiper to data", 2'd1, 2'd2);
    endtask

    // R6: all-channel copies, channel field ignored.
    task automatic t_global();
        issue(OP_GLOB_W2D, 2'd3, 2'd2, 8'h00);
        for (int c = 0; c < 4; c++) md[c][3] = mw[c];
        check_eq("R6 global store busy", 32'(nv_busy), 32'd1);
        wait_idle();
        read_dr("R6 global store ch3", 2'd3, 2'd3);
        read_dr("R6 global store ch0", 2'd3, 2'd0);
        issue(OP_WR_WIP, 2'd0, 2'd0, 8'hEE);
        issue(OP_WR_WIP, 2'd0, 2'd3, 8'h0D);
        issue(OP_GLOB_D2W, 2'd3, 2'd1, 8'h00);
        for (int c = 0; c < 4; c++) mw[c] = md[c][3];
        check_wipers("R6 global load");
        issue(OP_GLOB_D2W, 2'd2, 2'd0, 8'h00);
        for (int c = 0; c < 4; c++) mw[c] = md[c][2];
        check_wipers("R6 global load reg2");
    endtask

    // R10: write protect.
    task automatic t_wp();
        wp_n = 1'b0;
        issue(OP_WR_DR, 2'd0, 2'd0, 8'h77);
        check_eq("R10 no busy store", 32'(nv_busy), 32'd0);
        issue(OP_XFER_W2D, 2'd0, 2'd1, 8'h00);
        check_eq("R10 no busy copy", 32'(nv_busy), 32'd0);
        issue(OP_GLOB_W2D, 2'd2, 2'd0, 8'h00);
        check_eq("R10 no busy global", 32'(nv_busy), 32'd0);
        issue(OP_WR_WIP, 2'd0, 2'd0, 8'h5A);
        mw[0] = 8'h5A;
        check_wipers("R10 wiper write allowed");
        read_dr("R10 ch0 reg0 intact", 2'd0, 2'd0);
        read_dr("R10 ch1 reg0 intact", 2'd0, 2'd1);
        read_dr("R10 ch3 reg2 intact", 2'd2, 2'd3);
        wp_n = 1'b1;
    endtask

    // R11, R7: unknown opcodes and wrong status field.
    task automatic t_unlisted();
        logic [3:0] ops [7] = '{4'h0, 4'h2, 4'h3, 4'h4, 4'h6, 4'h7, 4'hF};
        for (int i = 0; i < 7; i++) begin
            issue(ops[i], 2'd3, 2'd3, 8'hFF);
            check_eq("R11 no strobe", 32'(got_v), 32'd0);
            check_eq("R11 no busy", 32'(nv_busy), 32'd0);
        end
        check_wipers("R11 wipers unchanged");
        read_dr("R11 ch3 reg3 unchanged", 2'd3, 2'd3);
        issue(OP_STATUS, 2'd0, 2'd2, 8'h00);
        check_eq("R7 wrong field no strobe", 32'(got_v), 32'd0);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        t_reset_recall();
        t_wiper_rw();
        t_dr_store();
        t_busy_ignore();
        t_xfer();
        t_global();
        t_wp();
        t_unlisted();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule